// File: doc/BRIEF.md
# Excluding Random Tag Picker

This block hands out a fresh 4-bit memory tag for each new allocation. Each request carries the tag that was last given out in the same region, the tags of the allocations on either side, and a 16-bit static mask of reserved values. It also carries a flag that turns on exclusion of the three per-request tags. A free-running linear feedback shift register supplies the entropy. A two-stage pipeline folds that entropy onto the set of tags still permitted, so an excluded value never comes out and every answer takes the same number of cycles.

The allocator raises a request strobe for one cycle with the side information. Two rising edges later it reads the tag together with a valid strobe. Requests may be issued on back-to-back cycles, and each one gets its own answer in order. If nothing is left to choose from, the block still answers on time. It returns the lowest tag that is not statically reserved and raises an error flag.

Top module: `tag_picker`

## Requirements
- R1: While `rst_n` is low at a rising edge, `tag_vld_o`, `empty_err_o` and `tag_o` are all zero after that edge.
- R2: When `req_i` is high at rising edge n, `tag_vld_o` is high after edge n+1. When `req_i` is low at edge n, `tag_vld_o` is low after edge n+1. Requests on consecutive cycles each produce one result, in order.
- R3: Tag t is allowed only if bit t of `static_excl_i` is 0. When `dyn_en_i` is 1, t must also differ from `prev_tag_i`, `left_tag_i` and `right_tag_i`. With the customary mask 16'h0001, tag 0 is reserved.
- R4: Whenever at least one tag is allowed, the returned tag is an allowed one.
- R5: When `dyn_en_i` is 0, `prev_tag_i`, `left_tag_i` and `right_tag_i` have no effect on the result.
- R6: The entropy register is 16 bits wide. While reset is low, it loads `seed_i`, or 16'hACE1 if `seed_i` is zero. At every rising edge out of reset it becomes {q[14:0], q[15]^q[13]^q[12]^q[10]}, so it is never zero.
- R7: Let r be bits [7:0] of the entropy register during the request cycle, and c the number of allowed tags (c > 0). The result is allowed tag number (r mod c), counting allowed tags upward from tag 0, with the first one numbered 0.
- R8: If no tag is allowed, the result is the lowest tag whose static mask bit is 0, or 0 if all static bits are 1. `empty_err_o` is high in the same cycle as `tag_vld_o`.
- R9: `empty_err_o` is high only in a valid cycle whose allowed set was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| seed_i | input | 16 | Entropy seed, loaded while reset is low |
| req_i | input | 1 | One-cycle request for a new tag |
| prev_tag_i | input | 4 | Tag last handed out in this region |
| left_tag_i | input | 4 | Tag of the lower neighbouring allocation |
| right_tag_i | input | 4 | Tag of the upper neighbouring allocation |
| static_excl_i | input | 16 | Bit t set reserves tag t for this request |
| dyn_en_i | input | 1 | Enables exclusion of the three per-request tags |
| tag_o | output | 4 | Chosen tag |
| tag_vld_o | output | 1 | Result strobe, one cycle per request |
| empty_err_o | output | 1 | Allowed set was empty; fallback tag returned |

## Verification
Every result is due after the second rising edge following the edge that sampled the request. The entropy value that decides it is the one held during the request cycle. The bench drives inputs on falling edges. It keeps its own copy of the shift register, advanced on the same edges, and records the expected tag and error flag for each request at the moment the request is driven. Two falling edges later it compares the outputs against that record. This holds for isolated requests, where it also confirms the strobe is absent one cycle early and one cycle late, and for long back-to-back streams with idle gaps.

// File: rtl/tp_pkg.sv
`timescale 1ns/1ps
package tp_pkg;
    localparam int TAG_W    = 4;
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int CNT_W    = $clog2(NUM_TAGS + 1);
    localparam int LFSR_W   = 16;
    localparam int RND_W    = 8;

    typedef struct packed {
        logic                vld;
        logic [NUM_TAGS-1:0] allowed;
        logic [CNT_W-1:0]    cnt;
        logic [RND_W-1:0]    rnd;
        logic [TAG_W-1:0]    fallback;
    } pick_s;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic             err;
    } res_s;

    typedef struct packed {
        pick_s pick;
        res_s  res;
    } state_s;
endpackage

// File: rtl/tp_lfsr.sv
`timescale 1ns/1ps
module tp_lfsr #(
    parameter int          W        = 16,
    parameter logic [W-1:0] TAPS     = 16'hB400,
    parameter logic [W-1:0] FALLBACK = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= (seed_i == '0) ? FALLBACK : seed_i;
        else        lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;
endmodule

// File: rtl/tp_mask.sv
`timescale 1ns/1ps
module tp_mask
    import tp_pkg::*;
(
    input  logic [NUM_TAGS-1:0] static_i,
    input  logic                dyn_en_i,
    input  logic [TAG_W-1:0]    prev_i,
    input  logic [TAG_W-1:0]    left_i,
    input  logic [TAG_W-1:0]    right_i,
    output logic [NUM_TAGS-1:0] allowed_o,
    output logic [CNT_W-1:0]    cnt_o,
    output logic [TAG_W-1:0]    fallback_o
);
    localparam logic [NUM_TAGS-1:0] ONE = {{(NUM_TAGS-1){1'b0}}, 1'b1};

    logic [NUM_TAGS-1:0] excl;

    always_comb begin
        excl = static_i;
        if (dyn_en_i) excl = excl | (ONE << prev_i) | (ONE << left_i) | (ONE << right_i);
        allowed_o = ~excl;

        cnt_o = '0;
        for (int i = 0; i < NUM_TAGS; i++) cnt_o = cnt_o + CNT_W'(allowed_o[i]);

        fallback_o = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--)
            if (!static_i[i]) fallback_o = TAG_W'(i);
    end
endmodule

// File: rtl/tp_select.sv
`timescale 1ns/1ps
module tp_select
    import tp_pkg::*;
(
    input  logic [NUM_TAGS-1:0] allowed_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [RND_W-1:0]    rnd_i,
    output logic [TAG_W-1:0]    tag_o
);
    logic [RND_W-1:0] cnt_ext;
    logic [RND_W-1:0] idx;
    logic [CNT_W-1:0] seen;

    always_comb begin
        cnt_ext = RND_W'(cnt_i);
        idx     = (cnt_i == '0) ? '0 : (rnd_i % cnt_ext);
        seen    = '0;
        tag_o   = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (allowed_i[i]) begin
                if (RND_W'(seen) == idx) tag_o = TAG_W'(i);
                seen = seen + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tag_picker.sv
`timescale 1ns/1ps
module tag_picker
    import tp_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED_FALLBACK = 16'hACE1,
    parameter logic [LFSR_W-1:0] LFSR_TAPS     = 16'hB400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LFSR_W-1:0]   seed_i,
    input  logic                req_i,
    input  logic [TAG_W-1:0]    prev_tag_i,
    input  logic [TAG_W-1:0]    left_tag_i,
    input  logic [TAG_W-1:0]    right_tag_i,
    input  logic [NUM_TAGS-1:0] static_excl_i,
    input  logic                dyn_en_i,
    output logic [TAG_W-1:0]    tag_o,
    output logic                tag_vld_o,
    output logic                empty_err_o
);
    state_s              st_d, st_q;
    logic [LFSR_W-1:0]   lfsr_q;
    logic [NUM_TAGS-1:0] allowed_w;
    logic [CNT_W-1:0]    cnt_w;
    logic [TAG_W-1:0]    fallback_w;
    logic [TAG_W-1:0]    sel_tag_w;

    tp_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .FALLBACK(SEED_FALLBACK)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .seed_i  (seed_i),
        .state_o (lfsr_q)
    );

    tp_mask u_mask (
        .static_i   (static_excl_i),
        .dyn_en_i   (dyn_en_i),
        .prev_i     (prev_tag_i),
        .left_i     (left_tag_i),
        .right_i    (right_tag_i),
        .allowed_o  (allowed_w),
        .cnt_o      (cnt_w),
        .fallback_o (fallback_w)
    );

    tp_select u_sel (
        .allowed_i (st_q.pick.allowed),
        .cnt_i     (st_q.pick.cnt),
        .rnd_i     (st_q.pick.rnd),
        .tag_o     (sel_tag_w)
    );

    always_comb begin
        st_d = st_q;
        // stage 1: capture the allowed set and the entropy of the request cycle
        st_d.pick.vld      = req_i;
        st_d.pick.allowed  = allowed_w;
        st_d.pick.cnt      = cnt_w;
        st_d.pick.rnd      = lfsr_q[RND_W-1:0];
        st_d.pick.fallback = fallback_w;
        // stage 2: fold the entropy onto the allowed set
        st_d.res.vld = st_q.pick.vld;
        st_d.res.tag = '0;
        st_d.res.err = 1'b0;
        if (st_q.pick.vld) begin
            if (st_q.pick.cnt == '0) begin
                st_d.res.tag = st_q.pick.fallback;
                st_d.res.err = 1'b1;
            end else begin
                st_d.res.tag = sel_tag_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tag_o       = st_q.res.tag;
    assign tag_vld_o   = st_q.res.vld;
    assign empty_err_o = st_q.res.err;
endmodule

// File: rtl/tp_checker.sv
`timescale 1ns/1ps
module tp_checker
    import tp_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                req_i,
    input logic [TAG_W-1:0]    prev_tag_i,
    input logic [TAG_W-1:0]    left_tag_i,
    input logic [TAG_W-1:0]    right_tag_i,
    input logic [NUM_TAGS-1:0] static_excl_i,
    input logic                dyn_en_i,
    input logic [TAG_W-1:0]    tag_o,
    input logic                tag_vld_o,
    input logic                empty_err_o,
    input logic [LFSR_W-1:0]   lfsr_q
);
    localparam logic [NUM_TAGS-1:0] ONE = {{(NUM_TAGS-1){1'b0}}, 1'b1};

    logic                req1, req2, dyn1, dyn2;
    logic [TAG_W-1:0]    p1, p2, l1, l2, r1, r2;
    logic [NUM_TAGS-1:0] s1, s2, excl2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req1 <= 1'b0; req2 <= 1'b0; dyn1 <= 1'b0; dyn2 <= 1'b0;
            p1 <= '0; p2 <= '0; l1 <= '0; l2 <= '0; r1 <= '0; r2 <= '0;
            s1 <= '0; s2 <= '0;
        end else begin
            req1 <= req_i; dyn1 <= dyn_en_i; p1 <= prev_tag_i; l1 <= left_tag_i;
            r1 <= right_tag_i; s1 <= static_excl_i;
            req2 <= req1; dyn2 <= dyn1; p2 <= p1; l2 <= l1; r2 <= r1; s2 <= s1;
        end
    end

    assign excl2 = s2 | (dyn2 ? ((ONE << p2) | (ONE << l2) | (ONE << r2)) : '0);

    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> ##1 tag_vld_o);                                          // R2
    AST_VLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tag_vld_o |-> req2);                                               // R2
    AST_NOT_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_vld_o && !empty_err_o) |-> !excl2[tag_o]);                    // R4
    AST_ERR_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        empty_err_o |-> tag_vld_o);                                        // R8
    AST_ERR_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        empty_err_o |-> (excl2 == '1));                                    // R9
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);                                                     // R6
endmodule

bind tag_picker tp_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .prev_tag_i    (prev_tag_i),
    .left_tag_i    (left_tag_i),
    .right_tag_i   (right_tag_i),
    .static_excl_i (static_excl_i),
    .dyn_en_i      (dyn_en_i),
    .tag_o         (tag_o),
    .tag_vld_o     (tag_vld_o),
    .empty_err_o   (empty_err_o),
    .lfsr_q        (lfsr_q)
);

// File: tb/tb_tag_picker.sv
`timescale 1ns/1ps
module tb_tag_picker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] seed_i;
    logic        req_i;
    logic [3:0]  prev_tag_i, left_tag_i, right_tag_i;
    logic [15:0] static_excl_i;
    logic        dyn_en_i;
    logic [3:0]  tag_o;
    logic        tag_vld_o, empty_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m;                     // bench copy of the entropy register (R6)
    logic        exp_v [0:4095];
    logic [4:0]  exp_r [0:4095];
    logic [15:0] exp_x [0:4095];

    always #4 clk = ~clk;               // 125 MHz

    tag_picker dut (
        .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .req_i(req_i),
        .prev_tag_i(prev_tag_i), .left_tag_i(left_tag_i), .right_tag_i(right_tag_i),
        .static_excl_i(static_excl_i), .dyn_en_i(dyn_en_i),
        .tag_o(tag_o), .tag_vld_o(tag_vld_o), .empty_err_o(empty_err_o)
    );

    always @(posedge clk) begin
        if (!rst_n) m <= (seed_i == 16'h0) ? 16'hACE1 : seed_i;
        else        m <= {m[14:0], m[15] ^ m[13] ^ m[12] ^ m[10]};
    end

    function automatic logic [15:0] excl_of(input logic [15:0] st, input logic dyn,
                                            input logic [3:0] p, l, r);
        logic [15:0] ex = st;
        if (dyn) begin ex[p] = 1'b1; ex[l] = 1'b1; ex[r] = 1'b1; end
        return ex;
    endfunction

    // {err, tag} per R3, R7, R8
    function automatic logic [4:0] model_pick(input logic [15:0] st, input logic [15:0] ex,
                                              input logic [15:0] lf);
        int cnt = 0;
        int idx;
        int seen = 0;
        logic [3:0] t = 4'h0;
        for (int i = 0; i < 16; i++) if (!ex[i]) cnt++;
        if (cnt == 0) begin
            for (int i = 15; i >= 0; i--) if (!st[i]) t = 4'(i);
            return {1'b1, t};
        end
        idx = int'(lf[7:0]) % cnt;
        for (int i = 0; i < 16; i++)
            if (!ex[i]) begin
                if (seen == idx) t = 4'(i);
                seen++;
            end
        return {1'b0, t};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] st, input logic dyn,
                         input logic [3:0] p, l, r);
        req_i = 1'b1; static_excl_i = st; dyn_en_i = dyn;
        prev_tag_i = p; left_tag_i = l; right_tag_i = r;
    endtask

    // single isolated request, caller is at a falling edge
    task automatic one_shot(input logic [15:0] st, input logic dyn,
                            input logic [3:0] p, l, r, input string lbl);
        logic [4:0] e;
        drive(st, dyn, p, l, r);
        e = model_pick(st, excl_of(st, dyn, p, l, r), m);
        @(negedge clk);
        req_i = 1'b0;
        chk(tag_vld_o == 1'b0, "R2 early", tag_vld_o, 0);
        @(negedge clk);
        chk(tag_vld_o == 1'b1, "R2 due", tag_vld_o, 1);
        chk(tag_o == e[3:0], lbl, tag_o, e[3:0]);
        chk(empty_err_o == e[4], e[4] ? "R8 flag" : "R9 flag", empty_err_o, e[4]);
        @(negedge clk);
        chk(tag_vld_o == 1'b0, "R2 late", tag_vld_o, 0);
    endtask

    task automatic stream(input int n);
        for (int j = 0; j < n + 2; j++) begin
            if (j >= 2) begin
                int k = j - 2;
                if (exp_v[k]) begin
                    chk(tag_vld_o == 1'b1, "R2 stream", tag_vld_o, 1);
                    chk(tag_o == exp_r[k][3:0], "R7 stream", tag_o, exp_r[k][3:0]);
                    chk(empty_err_o == exp_r[k][4], "R8 R9 stream", empty_err_o, exp_r[k][4]);
                    if (!exp_r[k][4]) chk(!exp_x[k][tag_o], "R4 stream", tag_o, -1);
                end else begin
                    chk(tag_vld_o == 1'b0, "R2 idle", tag_vld_o, 0);
                end
            end
            if (j < n) begin
                logic [15:0] st;
                int mode = int'($urandom % 4);
                logic [3:0] a = 4'($urandom), b = 4'($urandom);
                case (mode)
                    0: st = 16'h0001;
                    1: st = 16'($urandom);
                    2: st = ~((16'h1 << a) | (16'h1 << b));
                    default: st = ($urandom % 2) ? 16'hFFFF : 16'($urandom) | 16'($urandom);
                endcase
                drive(st, 1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
                if (mode == 2 && dyn_en_i) begin prev_tag_i = a; left_tag_i = b; end
                req_i = ($urandom % 8) != 0;
                exp_v[j] = req_i;
                exp_x[j] = excl_of(static_excl_i, dyn_en_i, prev_tag_i, left_tag_i, right_tag_i);
                exp_r[j] = model_pick(static_excl_i, exp_x[j], m);
            end else begin
                req_i = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; seed_i = 16'h1D2F; req_i = 1'b0;
        prev_tag_i = 0; left_tag_i = 0; right_tag_i = 0;
        static_excl_i = 16'h0001; dyn_en_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(tag_vld_o == 1'b0, "R1 vld", tag_vld_o, 0);
        chk(empty_err_o == 1'b0, "R1 err", empty_err_o, 0);
        chk(tag_o == 4'h0, "R1 tag", tag_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        one_shot(16'h0001, 1'b1, 4'd5, 4'd6, 4'd7, "R7 basic");
        one_shot(16'hFFF0, 1'b1, 4'd0, 4'd1, 4'd2, "R3 only tag 3 left");
        one_shot(16'hFFF7, 1'b0, 4'd3, 4'd3, 4'd3, "R5 dyn off keeps tag 3");
        one_shot(16'hFFF1, 1'b1, 4'd1, 4'd2, 4'd3, "R8 fallback 1");
        one_shot(16'hFFFF, 1'b0, 4'd0, 4'd0, 4'd0, "R8 fallback 0");
        one_shot(16'hFFFE, 1'b1, 4'd0, 4'd9, 4'd9, "R8 fallback 0 dyn");
        for (int i = 0; i < 16; i++)
            one_shot(16'h0001, 1'b1, 4'(i), 4'(i + 1), 4'(i + 2), "R3 R4 sweep");

        stream(3000);

        rst_n = 1'b0; seed_i = 16'h0000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        one_shot(16'h0001, 1'b0, 4'd0, 4'd0, 4'd0, "R6 zero seed");
        one_shot(16'h0000, 1'b0, 4'd0, 4'd0, 4'd0, "R6 zero seed next");
        stream(200);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule